// File: doc/BRIEF.md
# TDMA Slave Frame Timer with Presynchronization

This block is the slave-side frame timer of a time-division MAC. It counts clock cycles through a repeating frame. The frame holds one master slot, which is slot 0, followed by one slot for each slave. The slave with index k owns slot k+1. The slave's index comes from a static configuration input, normally set by switches.

After reset, or after the `sync_lost` input is raised, the timer sits in a listen-only presync state. In that state it never requests a transmission and its counter rests at zero. The first frame-start indication from the master preloads the counter with a fixed preset value and moves the block to fine-sync.

In fine-sync the counter advances once per cycle and wraps at the frame length. The block raises `tx_request` for one cycle at a fixed offset inside its own slot. A signed correction, presented with a valid strobe, trims the count. A negative correction rolls the count backwards, wrapping below zero to the end of the frame.

Top module: `tdma_slot_timer`

## Requirements
- R1: After reset `synced`, `tx_request` and `frame_pos` are all 0.
- R2: While not synced, `tx_request` stays 0 and `frame_pos` stays 0, whatever `corr_valid` and `corr_value` carry.
- R3: A `frame_start` sampled at a clock edge while not synced makes `synced` 1 and `frame_pos` equal to PRESET from the next cycle on.
- R4: While synced and with no correction, `frame_pos` rises by one each cycle and goes from FRAME_LEN-1 to 0, where FRAME_LEN = (NUM_SLAVES+1)*SLOT_LEN.
- R5: `slot_idx` equals `frame_pos` / SLOT_LEN, rounded down. `master_slot` is 1 exactly when `slot_idx` is 0.
- R6: `tx_request` is 1 exactly in the cycles where `synced` is 1 and `frame_pos` equals (`own_slave`+1)*SLOT_LEN+TX_OFFSET. Without corrections this gives one single-cycle pulse per frame.
- R7: A `corr_valid` sampled at an edge while synced makes the next `frame_pos` equal to (`frame_pos` + 1 + `corr_value`) modulo FRAME_LEN. `corr_value` is two's complement, and a negative value moves the count backwards across zero.
- R8: A `frame_start` while synced is ignored; the count continues as in R4 or R7.
- R9: A `sync_lost` sampled at an edge makes `synced` 0 and `frame_pos` 0 in the next cycle. It takes priority over a `frame_start` or a correction in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Master frame-start indication |
| sync_lost | input | 1 | Return to presync |
| own_slave | input | SLAVE_W | Static slave index; the slave owns slot own_slave+1 |
| corr_valid | input | 1 | Correction strobe |
| corr_value | input | CORR_W | Signed correction in cycles |
| synced | output | 1 | 1 in fine-sync |
| frame_pos | output | CNT_W | Cycle position in the frame |
| slot_idx | output | SLOT_W | Current slot number |
| master_slot | output | 1 | Current slot is the master slot |
| tx_request | output | 1 | Transmit request strobe |

## Verification
Several functions can meet in the same cycle, and the bench provokes each pairing on purpose:
- A correction can land on the same edge where the counter would wrap from FRAME_LEN-1 to 0. The bench strobes corrections at the last position, at position 0 and at small positions with negative values. The result must be the wrapped sum, not a plain wrap followed by the addition.
- `sync_lost` can coincide with `frame_start`, and also with a correction. In both cases the block must drop to presync with a zero count.

A cycle-accurate arithmetic model in the bench judges every output in every cycle, including the `tx_request` that a backward correction makes recur.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [0:0] {
    ST_LISTEN = 1'b0,
    ST_FINE   = 1'b1
  } sync_state_e;
endpackage

// File: rtl/tdma_sync_fsm.sv
module tdma_sync_fsm
  import tdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic sync_lost,
  output logic synced,
  output logic load_evt,
  output logic clear_evt
);
  sync_state_e state_q, state_d;

  // Named events for the counter and for the assertions.
  assign clear_evt = sync_lost;
  assign load_evt  = (state_q == ST_LISTEN) && frame_start && !sync_lost;

  always_comb begin
    state_d = state_q;
    if (clear_evt)     state_d = ST_LISTEN;
    else if (load_evt) state_d = ST_FINE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LISTEN;
    else        state_q <= state_d;
  end

  assign synced = (state_q == ST_FINE);

  p_lost_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !synced);
  p_start_enters_fine_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && frame_start && !sync_lost) |=> synced);
  p_fine_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !sync_lost) |=> synced);
endmodule

// File: rtl/tdma_frame_counter.sv
module tdma_frame_counter #(
  parameter int FRAME_LEN = 144,
  parameter int PRESET    = 2,
  parameter int CORR_W    = 8,
  parameter int CNT_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_evt,
  input  logic                     load_evt,
  input  logic                     run_en,
  input  logic                     corr_en,
  input  logic signed [CORR_W-1:0] corr_value,
  output logic [CNT_W-1:0]         count
);
  logic [CNT_W-1:0] count_d;
  logic             wrap_evt;

  // Advance by one plus a signed trim, modulo the frame length.
  // The trim magnitude is below FRAME_LEN, so one fold is enough.
  function automatic logic [CNT_W-1:0] wrap_advance(
    input logic [CNT_W-1:0]         cur,
    input logic signed [CORR_W-1:0] trim
  );
    int s;
    s = int'(cur) + 1 + int'(trim);
    if (s < 0)               s = s + FRAME_LEN;
    else if (s >= FRAME_LEN) s = s - FRAME_LEN;
    return CNT_W'(s);
  endfunction

  assign wrap_evt = run_en && !corr_en && (int'(count) == FRAME_LEN - 1);

  always_comb begin
    count_d = count;
    if (clear_evt)     count_d = '0;
    else if (load_evt) count_d = CNT_W'(PRESET);
    else if (corr_en)  count_d = wrap_advance(count, corr_value);
    else if (run_en)   count_d = wrap_advance(count, '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  p_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) < FRAME_LEN);
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !clear_evt) |=> (count == '0));
  p_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (int'(count) == PRESET));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (count == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_evt && !clear_evt) |=> $stable(count));
endmodule

// File: rtl/tdma_slot_decode.sv
module tdma_slot_decode #(
  parameter int NUM_SLOTS = 9,
  parameter int SLOT_LEN  = 16,
  parameter int TX_OFFSET = 5,
  parameter int CNT_W     = 8,
  parameter int SLOT_W    = 4,
  parameter int SLAVE_W   = 3
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [SLAVE_W-1:0] own_slave,
  input  logic               synced,
  output logic [SLOT_W-1:0]  slot_idx,
  output logic               master_slot,
  output logic               tx_request
);
  // Slot number by comparison against each slot boundary.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [CNT_W-1:0] c);
    int idx;
    idx = 0;
    for (int k = 1; k < NUM_SLOTS; k++) begin
      if (int'(c) >= k * SLOT_LEN) idx = k;
    end
    return SLOT_W'(idx);
  endfunction

  function automatic int tx_point(input logic [SLAVE_W-1:0] s);
    return (int'(s) + 1) * SLOT_LEN + TX_OFFSET;
  endfunction

  logic tx_hit;

  assign slot_idx    = slot_of(count);
  assign master_slot = (slot_idx == '0);
  assign tx_hit      = (int'(count) == tx_point(own_slave));
  assign tx_request  = synced && tx_hit;

  always_comb begin
    p_tx_own_slot_r6: assert (!tx_request || (int'(slot_idx) == int'(own_slave) + 1));
    p_tx_not_master_r5: assert (!(tx_request && master_slot));
  end
endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
  parameter int NUM_SLAVES = 8,
  parameter int SLOT_LEN   = 16,
  parameter int PRESET     = 2,
  parameter int TX_OFFSET  = 5,
  parameter int CORR_W     = 8,
  localparam int NUM_SLOTS = NUM_SLAVES + 1,
  localparam int FRAME_LEN = NUM_SLOTS * SLOT_LEN,
  localparam int CNT_W     = $clog2(FRAME_LEN),
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SLAVE_W   = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     sync_lost,
  input  logic [SLAVE_W-1:0]       own_slave,
  input  logic                     corr_valid,
  input  logic signed [CORR_W-1:0] corr_value,
  output logic                     synced,
  output logic [CNT_W-1:0]         frame_pos,
  output logic [SLOT_W-1:0]        slot_idx,
  output logic                     master_slot,
  output logic                     tx_request
);
  logic load_evt;
  logic clear_evt;
  logic corr_evt;

  assign corr_evt = synced && corr_valid;

  tdma_sync_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .sync_lost  (sync_lost),
    .synced     (synced),
    .load_evt   (load_evt),
    .clear_evt  (clear_evt)
  );

  tdma_frame_counter #(
    .FRAME_LEN(FRAME_LEN),
    .PRESET   (PRESET),
    .CORR_W   (CORR_W),
    .CNT_W    (CNT_W)
  ) i_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_evt (clear_evt),
    .load_evt  (load_evt),
    .run_en    (synced),
    .corr_en   (corr_evt),
    .corr_value(corr_value),
    .count     (frame_pos)
  );

  tdma_slot_decode #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_LEN (SLOT_LEN),
    .TX_OFFSET(TX_OFFSET),
    .CNT_W    (CNT_W),
    .SLOT_W   (SLOT_W),
    .SLAVE_W  (SLAVE_W)
  ) i_dec (
    .count      (frame_pos),
    .own_slave  (own_slave),
    .synced     (synced),
    .slot_idx   (slot_idx),
    .master_slot(master_slot),
    .tx_request (tx_request)
  );

  p_listen_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!tx_request && frame_pos == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !corr_valid && !sync_lost) |=>
      (int'(frame_pos) == (int'($past(frame_pos)) + 1) % FRAME_LEN));
  p_trim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && corr_valid && !sync_lost) |=>
      (int'(frame_pos) == ((int'($past(frame_pos)) + 1 + int'($past(corr_value))
                            + FRAME_LEN) % FRAME_LEN)));
endmodule

// File: tb/test_tdma_slot_timer.sv
module test_tdma_slot_timer;
  localparam int NSL = 8;
  localparam int SL  = 16;
  localparam int PRE = 2;
  localparam int TXO = 5;
  localparam int FL  = (NSL + 1) * SL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic sync_lost = 1'b0;
  logic [2:0] own_slave = 3'd0;
  logic corr_valid = 1'b0;
  logic signed [7:0] corr_value = 8'sd0;
  logic synced;
  logic [7:0] frame_pos;
  logic [3:0] slot_idx;
  logic master_slot;
  logic tx_request;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // Bench model state.
  bit m_sync = 0;
  int m_pos = 0;

  always #4 clk = ~clk;

  tdma_slot_timer i_tdma_slot_timer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sync_lost(sync_lost),
    .own_slave(own_slave), .corr_valid(corr_valid), .corr_value(corr_value),
    .synced(synced), .frame_pos(frame_pos), .slot_idx(slot_idx),
    .master_slot(master_slot), .tx_request(tx_request)
  );

  task automatic cmp(input string t, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    int es;
    es = m_pos / SL;
    cmp(tag, "synced", int'(synced), int'(m_sync));
    cmp(tag, "frame_pos", int'(frame_pos), m_pos);
    cmp("R5", "slot_idx", int'(slot_idx), es);
    cmp("R5", "master_slot", int'(master_slot), (es == 0) ? 1 : 0);
    cmp("R6", "tx_request", int'(tx_request),
        (m_sync && m_pos == (int'(own_slave) + 1) * SL + TXO) ? 1 : 0);
  endtask

  // Drive one cycle's inputs (called just after a negedge), advance model, check.
  task automatic cyc(input bit fs, input bit sl, input bit cv, input int cval);
    frame_start = fs;
    sync_lost = sl;
    corr_valid = cv;
    corr_value = 8'(cval);
    if (sl) begin
      m_sync = 0; m_pos = 0;
    end else if (!m_sync) begin
      if (fs) begin m_sync = 1; m_pos = PRE; end
    end else if (cv) begin
      m_pos = ((m_pos + 1 + cval) % FL + FL) % FL;
    end else begin
      m_pos = (m_pos + 1) % FL;
    end
    @(posedge clk);
    @(negedge clk);
    frame_start = 0; sync_lost = 0; corr_valid = 0;
    check_all();
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2: listen state ignores corrections
    tag = "R2";
    for (int i = 0; i < 40; i++) cyc(0, 0, (i % 3) == 0, i * 7 - 100);

    // R3: frame start presets the counter
    tag = "R3";
    cyc(1, 0, 0, 0);

    // R4/R6: two frames for every slave index
    tag = "R4";
    for (int s = 0; s < NSL; s++) begin
      own_slave = 3'(s);
      for (int i = 0; i < 2 * FL; i++) cyc(0, 0, 0, 0);
    end

    // R8: frame_start while synced is ignored
    tag = "R8";
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);

    // R7: sweep every correction value, at rotating positions
    tag = "R7";
    own_slave = 3'd2;
    for (int v = -128; v < 128; v++) begin
      cyc(0, 0, 1, v);
      for (int k = 0; k < (v & 7); k++) cyc(0, 0, 0, 0);
    end

    // R7: correction on the wrap edge and backward across zero
    while (m_pos != FL - 1) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 1);
    while (m_pos != FL - 1) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, -1);
    cyc(0, 0, 1, -1);
    while (m_pos != 3) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, -10);
    cyc(0, 0, 1, -128);
    cyc(0, 0, 1, 127);

    // R6: backward trim right after the tx point repeats the request
    while (m_pos != (int'(own_slave) + 1) * SL + TXO) cyc(0, 0, 0, 0);
    cyc(0, 0, 1, -1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

    // R9: sync_lost beats frame_start and a correction
    tag = "R9";
    cyc(1, 1, 1, 50);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 5);
    tag = "R3";
    cyc(1, 0, 0, 0);
    tag = "R4";
    for (int i = 0; i < FL + 5; i++) cyc(0, 0, 0, 0);
    tag = "R9";
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule